// File: doc/BRIEF.md
# Gated Divided System Clock Output

This block produces the external system clock from the 30 MHz reference. A frequency-plan bit picks the ratio. With the bit low the reference is divided by 2 (15 MHz). With the bit high it is divided by 3 (10 MHz). The divide-by-3 path keeps a 50% duty cycle by combining one flop on the rising reference edge with one flop on the falling edge. The output then stays high for 1.5 reference periods and low for 1.5.

The output runs only while both conditions hold: the configuration strap permits the clock, and the device is in receive mode (the mode flag is high). When either condition goes away, the clock period in progress finishes in full and the pin then rests low. No shortened pulse appears. Each restart begins with a complete high phase.

The three control inputs come from outside the reference domain, so each passes through a two-stage synchronizer. The ratio bit is captured only while the output is stopped.

Top module: `sysclk_gate_div`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low whatever the other inputs do. After reset it stays low until the enable condition of R4 is met.
- R2: With the captured plan bit at 0, the output period is 2 reference cycles. It is high for exactly 1 cycle, starting at a rising reference edge.
- R3: With the captured plan bit at 1, the output period is 3 reference cycles. It is high for 1.5 cycles, from a rising reference edge to the falling edge of the following cycle, and low for 1.5 cycles.
- R4: The enable condition is `strap_en` AND `run_mode`, taken through a 2-stage synchronizer. Suppose the condition is true before rising reference edge k and the output is stopped. Then the first output rise occurs at rising edge k+2.
- R5: While `strap_en` is low, `clk_out` stays low, regardless of `run_mode` and `slow_plan`.
- R6: The enable condition is looked at only at the end of a full output period. If it has dropped, the output stops there and parks low. A drop that recovers before the period boundary does not interrupt the clock.
- R7: `slow_plan` is captured only while the output is stopped. A change made while the clock runs has no effect until the output stops and restarts.
- R8: Setting `run_mode` low (standby) stops the output at the next period boundary, as in R6.
- R9: Every start, after reset or after a stop, begins with a full-width high phase of the selected ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | 30 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_plan | input | 1 | Plan bit: 1 selects divide by 3, 0 selects divide by 2 |
| strap_en | input | 1 | Strap permission for the clock output, 1 = allowed |
| run_mode | input | 1 | Operating mode: 1 = receive, 0 = standby |
| clk_out | output | 1 | Gated divided clock pin |

## Verification
The output is compared at every half reference cycle against a model that counts half-periods. Because of this, a wrong duty cycle, a runt pulse or a late start all show up in a single sample. The bench drives several patterns, and each one separates a different fault:
- steady running at each ratio shows the duty and period;
- flipping the plan bit while running separates a frozen ratio from one that changes mid-stream;
- a one-cycle dip of `run_mode` separates gating at the period boundary from gating at once;
- toggling `run_mode` with the strap low shows that the strap overrides the mode.

Restarts after standby check that the first pulse has full width and appears at the right latency.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  // Synchronized control bits in one vector
  typedef struct packed {
    logic strap;
    logic run;
    logic slow;
  } ctrl_bits_t;

  function automatic int unsigned max_ratio(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Counter width needed to hold indices 0 .. r-1
  function automatic int unsigned cnt_width(int unsigned r);
    return (r <= 2) ? 1 : $clog2(r);
  endfunction

  // Full reference cycles the rising-edge flop stays high in one period
  function automatic int unsigned pos_high_cycles(int unsigned r);
    return r / 2;
  endfunction

  // Odd ratios need the falling-edge half-cycle extension
  function automatic bit needs_half(int unsigned r);
    return (r % 2) == 1;
  endfunction

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned DIV_FAST = 2,
  parameter int unsigned DIV_SLOW = 3,
  parameter int unsigned CW       = cnt_width(max_ratio(DIV_FAST, DIV_SLOW))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_sync,
  input  logic          slow_sync,
  output logic          active,
  output logic          slow_q,
  output logic          act_d,
  output logic          slow_d,
  output logic [CW-1:0] cnt_d
);

  localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_sel;
  logic          at_last;

  assign last_sel = slow_q ? LAST_SLOW : LAST_FAST;
  assign at_last  = active && (cnt == last_sel);

  // Enable is only looked at when idle or at a period boundary
  assign act_d  = active ? !(at_last && !en_sync) : en_sync;
  // Ratio is captured only while stopped
  assign slow_d = active ? slow_q : slow_sync;
  assign cnt_d  = (active && !at_last) ? cnt + CW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      slow_q <= 1'b0;
      cnt    <= '0;
    end else begin
      active <= act_d;
      slow_q <= slow_d;
      cnt    <= cnt_d;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= last_sel));

  assert_ratio_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(slow_q));

  assert_stop_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(at_last));

  assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(en_sync));

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !en_sync) |=> !active);

endmodule

// File: rtl/edge_shaper.sv
module edge_shaper
  import sysclk_pkg::*;
#(
  parameter int unsigned DIV_FAST = 2,
  parameter int unsigned DIV_SLOW = 3,
  parameter int unsigned CW       = cnt_width(max_ratio(DIV_FAST, DIV_SLOW))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_d,
  input  logic          slow_d,
  input  logic [CW-1:0] cnt_d,
  input  logic          slow_q,
  output logic          clk_out
);

  localparam logic [CW-1:0] HI_FAST  = CW'(pos_high_cycles(DIV_FAST));
  localparam logic [CW-1:0] HI_SLOW  = CW'(pos_high_cycles(DIV_SLOW));
  localparam bit            ODD_FAST = needs_half(DIV_FAST);
  localparam bit            ODD_SLOW = needs_half(DIV_SLOW);

  logic hi_pos;
  logic hi_neg;
  logic pos_nxt;
  logic use_half;

  assign pos_nxt  = act_d && (cnt_d < (slow_d ? HI_SLOW : HI_FAST));
  assign use_half = slow_q ? ODD_SLOW : ODD_FAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_pos <= 1'b0;
    else        hi_pos <= pos_nxt;
  end

  // Falling-edge copy stretches the high phase by half a reference cycle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hi_neg <= 1'b0;
    else        hi_neg <= hi_pos;
  end

  assign clk_out = hi_pos | (use_half & hi_neg);

  assert_neg_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_neg == hi_pos);

endmodule

// File: rtl/sysclk_gate_div.sv
module sysclk_gate_div
  import sysclk_pkg::*;
#(
  parameter int unsigned DIV_FAST    = 2,
  parameter int unsigned DIV_SLOW    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic slow_plan,
  input  logic strap_en,
  input  logic run_mode,
  output logic clk_out
);

  localparam int unsigned CW = cnt_width(max_ratio(DIV_FAST, DIV_SLOW));
  localparam int unsigned NB = $bits(ctrl_bits_t);

  ctrl_bits_t    raw_bits;
  ctrl_bits_t    sync_bits;
  logic [NB-1:0] sync_vec;
  logic          en_sync;
  logic          active;
  logic          slow_q;
  logic          act_d;
  logic          slow_d;
  logic [CW-1:0] cnt_d;

  assign raw_bits = '{strap: strap_en, run: run_mode, slow: slow_plan};

  sig_sync #(.WIDTH(NB), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (ref_clk),
    .rst_n(rst_n),
    .d    (raw_bits),
    .q    (sync_vec)
  );

  assign sync_bits = ctrl_bits_t'(sync_vec);
  assign en_sync   = sync_bits.strap & sync_bits.run;

  gate_ctrl #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .CW(CW)) u_gate (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .en_sync  (en_sync),
    .slow_sync(sync_bits.slow),
    .active   (active),
    .slow_q   (slow_q),
    .act_d    (act_d),
    .slow_d   (slow_d),
    .cnt_d    (cnt_d)
  );

  edge_shaper #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .CW(CW)) u_shape (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .act_d  (act_d),
    .slow_d (slow_d),
    .cnt_d  (cnt_d),
    .slow_q (slow_q),
    .clk_out(clk_out)
  );

  assert_strap_low_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!sync_bits.strap && !active) |=> !clk_out);

endmodule

// File: tb/sysclk_gate_div_tb_top.sv
module sysclk_gate_div_tb_top;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_plan = 1'b0;
  logic strap_en = 1'b0;
  logic run_mode = 1'b0;
  logic clk_out;

  always #2 ref_clk = ~ref_clk;

  sysclk_gate_div dut_i (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .slow_plan(slow_plan),
    .strap_en (strap_en),
    .run_mode (run_mode),
    .clk_out  (clk_out)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  logic  exp_q[$];
  string tag_q[$];

  task automatic check(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: clk_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: half-period phase within an output period
  logic h1_en, h2_en, h1_sl, h2_sl, dec_en, dec_sl;
  bit   m_on;
  int   m_r, m_h;

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      h1_en = 0; h2_en = 0; h1_sl = 0; h2_sl = 0;
      m_on = 0; m_r = 2; m_h = 0;
    end else begin
      dec_en = h2_en; dec_sl = h2_sl;          // R4: two-edge latency
      h2_en = h1_en;  h2_sl = h1_sl;
      h1_en = strap_en & run_mode; h1_sl = slow_plan;
      if (!m_on) begin
        if (dec_en) begin
          m_on = 1; m_r = dec_sl ? 3 : 2; m_h = 0;   // R7, R9
        end
      end else begin
        m_h += 2;
        if (m_h >= 2 * m_r) begin
          m_h = 0;
          if (!dec_en) m_on = 0;                 // R6, R8
        end
      end
      exp_q.push_back(m_on && (m_h < m_r));
      tag_q.push_back(cur_tag);
      exp_q.push_back(m_on && (m_h + 1 < m_r));
      tag_q.push_back(cur_tag);
    end
  end

  // Monitor: one sample per half reference cycle
  initial begin
    forever begin
      @(posedge ref_clk);
      #1;
      if (exp_q.size() > 0) check(clk_out, exp_q.pop_front(), tag_q.pop_front());
      #2;
      if (exp_q.size() > 0) check(clk_out, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic phase(input logic s, input logic r, input logic sl, input int n,
                       input string tag);
    @(posedge ref_clk);
    #3;
    strap_en = s; run_mode = r; slow_plan = sl; cur_tag = tag;
    repeat (n - 1) @(posedge ref_clk);
  endtask

  initial begin
    // R1: held low in reset even with enable asserted
    strap_en = 1; run_mode = 1;
    for (int i = 0; i < 4; i++) begin
      #3;
      check(clk_out, 1'b0, "R1");
    end
    @(posedge ref_clk); #3;
    strap_en = 0; run_mode = 0;
    rst_n = 1;
    phase(0, 0, 0, 6, "R1");
    phase(1, 1, 0, 20, "R2 R4 R9");
    phase(1, 1, 1, 12, "R7");
    phase(1, 0, 1, 12, "R8 R6");
    phase(1, 1, 1, 24, "R3 R9");
    phase(0, 1, 1, 10, "R5 R6");
    for (int k = 0; k < 4; k++) begin
      phase(0, 0, 0, 3, "R5");
      phase(0, 1, 1, 3, "R5");
    end
    phase(1, 1, 1, 10, "R3 R4");
    for (int k = 0; k < 5; k++) begin
      phase(1, 0, 1, 1, "R6");
      phase(1, 1, 1, 4, "R6");
    end
    phase(1, 0, 1, 8, "R8");
    phase(1, 1, 0, 16, "R7 R2");
    for (int k = 0; k < 3; k++) begin
      phase(1, 0, 0, 1, "R6");
      phase(1, 1, 0, 3, "R6");
    end
    phase(0, 0, 0, 10, "R5 R6");
    repeat (4) @(posedge ref_clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done) begin
      miscompares++;
      $display("FAIL %s: watchdog, run not finished (actual hung, expected done)", cur_tag);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule